// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block collects six asynchronous interrupt source lines into one interrupt request. Each source line passes through its own synchroniser. A rising edge on a source whose enable bit is set makes that source's status bit sticky-high. The interrupt request fires when the status word as a whole goes from zero to non-zero. After that it stays quiet until every status bit has been cleared again.

There is no clear register. Software clears a status bit only by clearing the matching enable bit, and can re-enable the source afterwards. A small register port lets software write the enable word and read back either the enable word or the status word. A parameter chooses the form of the request:
- a one-cycle pulse on the zero-to-nonzero transition, or
- a level that stays high while any status bit is set.

Top module: `eirq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the enable word and the status word are zero and `irq_o` is low.
- R2: A write with `reg_addr`=1 loads `reg_wdata` into the enable word. A write with `reg_addr`=0 changes neither the enable word nor the status word.
- R3: A rising edge on source n, with enable bit n set, sets status bit n. The bit becomes visible after the third rising clock edge that follows the input change: two synchroniser stages, then the edge compare.
- R4: A rising edge on a source whose enable bit is clear leaves the status word unchanged.
- R5: Clearing enable bit n clears status bit n on the same clock edge that loads the write. If an edge on source n is latched on that same clock edge, the clear takes precedence.
- R6: A status bit that is set stays set while its enable bit stays set, whatever the source line does afterwards.
- R7: In pulse mode (`LEVEL_IRQ`=0), `irq_o` is high for exactly one cycle: the first cycle in which the status word is non-zero after a cycle in which it was zero.
- R8: While the status word stays non-zero, further latched edges produce no further pulse.
- R9: In level mode (`LEVEL_IRQ`=1), `irq_o` is high exactly while the status word is non-zero.
- R10: `reg_rdata` holds the status word when `reg_addr`=0 and the enable word when `reg_addr`=1, with bit n belonging to source n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NSRC | Asynchronous interrupt source lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = status, 1 = enable |
| reg_wdata | input | NSRC | Write data for the enable word |
| reg_rdata | output | NSRC | Read data for the selected register |
| irq_o | output | 1 | Interrupt request, pulse or level by parameter |

## Verification
The bench drives an edge into the synchroniser so that it is latched on the same clock edge as a write that clears its enable. A design that lets the edge win would leave a stale status bit set.

It also raises a second source while the status word is already non-zero. A design that fires on every new bit, rather than on the whole word leaving zero, would emit a second pulse.

Edges on disabled sources, and writes to the status address, must leave the readback unchanged. A design that latches without checking the enable bit, or that decodes the address loosely, would corrupt the status word.

Randomised traffic also compares the pulse-mode and level-mode request outputs against a cycle model on every cycle. That catches an off-by-one in the synchroniser depth.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  // Register select values on the register port
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/eirq_sync_edge.sv
// Two-flop synchroniser per source followed by a rising-edge compare.
module eirq_sync_edge #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] rise_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= async_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign rise_o[i] = sync_q & ~prev_q;

    // R3: an edge indication lasts a single cycle
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/eirq_status_regs.sv
// Enable and sticky status registers; disabling a source clears its bit.
module eirq_status_regs #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rise_i,
  input  logic             en_wr_i,
  input  logic [WIDTH-1:0] en_wdata_i,
  output logic [WIDTH-1:0] en_o,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] en_q, en_d;
  logic [WIDTH-1:0] st_q, st_d;

  always_comb begin
    en_d = en_q;
    if (en_wr_i) en_d = en_wdata_i;
    // latch only edges of currently enabled sources; new enable masks last
    st_d = (st_q | (rise_i & en_q)) & en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      en_q <= en_d;
      st_q <= st_d;
    end
  end

  assign en_o     = en_q;
  assign status_o = st_q;

  // R5
  status_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q & ~en_q) == '0);

  // R4
  no_disabled_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(st_q) & en_q) & ~st_q) == '0));
endmodule

// File: rtl/eirq_notify.sv
// Converts "status word non-zero" into a pulse or a level request.
module eirq_notify #(
  parameter bit LEVEL_IRQ = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_i,
  output logic irq_o
);
  logic any_q, any_d;

  always_comb any_d = any_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_q <= 1'b0;
    else        any_q <= any_d;
  end

  if (LEVEL_IRQ) begin : g_level
    assign irq_o = any_i;
  end else begin : g_pulse
    assign irq_o = any_i & ~any_q;

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_i && $past(any_i)) |-> !irq_o);
  end
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
#(
  parameter int NSRC      = 6,
  parameter bit LEVEL_IRQ = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            reg_wr,
  input  logic            reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq_o
);
  localparam int RST_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] en_word, st_word;
  logic            en_wr;
  reg_sel_e        sel;

  assign sel   = reg_sel_e'(reg_addr);
  assign en_wr = reg_wr && (sel == SEL_ENABLE);

  eirq_sync_edge #(.WIDTH(NSRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (src_i),
    .rise_o  (rise)
  );

  eirq_status_regs #(.WIDTH(NSRC)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rise_i     (rise),
    .en_wr_i    (en_wr),
    .en_wdata_i (reg_wdata),
    .en_o       (en_word),
    .status_o   (st_word)
  );

  eirq_notify #(.LEVEL_IRQ(LEVEL_IRQ)) u_notify (
    .clk   (clk),
    .rst_n (rst_int_n),
    .any_i (|st_word),
    .irq_o (irq_o)
  );

  always_comb begin
    reg_rdata = (sel == SEL_ENABLE) ? en_word : st_word;
  end

  // R2
  status_addr_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr && sel == SEL_STATUS) |=> $stable(en_word));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (!irq_o && st_word == '0 && en_word == '0));
endmodule

// File: tb/eirq_ctrl_test.sv
module eirq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic         wr = 1'b0;
  logic         addr = 1'b0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, rdata_lvl;
  logic         irq, irq_lvl;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;
  logic [N-1:0] m_en = '0, m_st = '0;
  logic         m_any_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eirq_ctrl #(.NSRC(N), .LEVEL_IRQ(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq));

  eirq_ctrl #(.NSRC(N), .LEVEL_IRQ(1'b1)) uut_lvl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata_lvl), .irq_o(irq_lvl));

  function automatic logic [N-1:0] exp_read(input logic a);
    return a ? m_en : m_st;
  endfunction

  function automatic logic exp_pulse();
    return (|m_st) & ~m_any_d;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic [N-1:0] s, input logic w, input logic a,
                      input logic [N-1:0] d, input string req);
    logic [N-1:0] rise, en_n;
    src = s; wr = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    rise    = m_s2 & ~m_s3;
    en_n    = (w && a) ? d : m_en;
    m_any_d = |m_st;
    m_st    = (m_st | (rise & m_en)) & en_n;
    m_en    = en_n;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = s;
    @(negedge clk);
    check({req, " R10 read"}, rdata, exp_read(a));
    check({req, " R7 irq pulse"}, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, exp_pulse()});
    check({req, " R9 irq level"}, {{(N-1){1'b0}}, irq_lvl}, {{(N-1){1'b0}}, |m_st});
    check({req, " R9 level read"}, rdata_lvl, exp_read(a));
  endtask

  logic done = 1'b0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1 irq in reset", {{(N-1){1'b0}}, irq}, '0);
    check("R1 status in reset", rdata, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step('0, 1'b0, 1'b0, '0, "R1 status");
    step('0, 1'b0, 1'b1, '0, "R1 enable");

    // R2: enable sources 0 and 2
    step('0, 1'b1, 1'b1, 6'b000101, "R2 write");
    step('0, 1'b0, 1'b1, '0, "R2 readback");
    check("R2 enable word", rdata, 6'b000101);

    // R3 / R7: edge on source 0
    step(6'b000001, 1'b0, 1'b0, '0, "R3 edge c1");
    step(6'b000001, 1'b0, 1'b0, '0, "R3 edge c2");
    check("R3 not yet latched", rdata, 6'b000000);
    step(6'b000001, 1'b0, 1'b0, '0, "R3 edge c3");
    check("R3 latched", rdata, 6'b000001);
    check("R7 pulse high", {{(N-1){1'b0}}, irq}, 6'b000001);
    step(6'b000001, 1'b0, 1'b0, '0, "R7 after");
    check("R7 pulse one cycle", {{(N-1){1'b0}}, irq}, '0);

    // R4: disabled source 1
    repeat (4) step(6'b000011, 1'b0, 1'b0, '0, "R4 disabled");
    check("R4 status unchanged", rdata, 6'b000001);

    // R8: second enabled source while non-zero
    repeat (4) step(6'b000111, 1'b0, 1'b0, '0, "R8 no repulse");
    check("R8 status", rdata, 6'b000101);

    // R6: sources fall, bits stay
    repeat (4) step('0, 1'b0, 1'b0, '0, "R6 sticky");
    check("R6 status kept", rdata, 6'b000101);

    // R2: write to status address ignored
    step('0, 1'b1, 1'b0, 6'b111111, "R2 ignored write");
    step('0, 1'b0, 1'b0, '0, "R2 ignored write");
    check("R2 status after addr0 write", rdata, 6'b000101);
    step('0, 1'b0, 1'b1, '0, "R2 ignored write");
    check("R2 enable after addr0 write", rdata, 6'b000101);

    // R5: clear bit 2 only, then bit 0; then re-enable and clear-wins race
    step('0, 1'b1, 1'b1, 6'b000001, "R5 clear2");
    step('0, 1'b0, 1'b0, '0, "R5 clear2");
    check("R5 bit2 cleared", rdata, 6'b000001);
    step('0, 1'b1, 1'b1, 6'b000000, "R5 clear0");
    step('0, 1'b0, 1'b0, '0, "R5 clear0");
    check("R5 all cleared", rdata, 6'b000000);
    step('0, 1'b1, 1'b1, 6'b001000, "R5 en3");
    step(6'b001000, 1'b0, 1'b0, '0, "R5 race c1");
    step(6'b001000, 1'b0, 1'b0, '0, "R5 race c2");
    step(6'b001000, 1'b1, 1'b1, 6'b000000, "R5 race c3");
    step(6'b001000, 1'b0, 1'b0, '0, "R5 race result");
    check("R5 clear wins", rdata, 6'b000000);
    check("R5 no pulse", {{(N-1){1'b0}}, irq}, '0);

    // random traffic
    for (int i = 0; i < 1500; i++) begin
      logic [N-1:0] s, d;
      logic w, a;
      s = N'($urandom);
      w = ($urandom % 8) == 0;
      a = 1'($urandom);
      d = N'($urandom);
      step(s, w, a, d, "R3 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule